// File: doc/BRIEF.md
# Control-Word Steered Register Datapath

This block is a small execution datapath: seven general-purpose registers feed one shared arithmetic and logic unit through two source multiplexers. A single 14-bit control word arrives every cycle. It names the register that drives bus A, the register that drives bus B, the operation the ALU performs, and the register that captures the result at the next rising clock edge.

Source code zero is special. On either source field it selects the external data input instead of a register. On the destination field it suppresses every register write. The ALU result and its four status flags are driven combinationally to the output ports in every cycle, whatever the destination field holds.

Whatever produces the control words, microcode or hardwired logic, sits outside this block. The data width is a parameter and defaults to 8 bits.

Top module: `cwdp_top`

## Requirements
- R1: The control word `ctrl` is packed with bits [13:11] as source-A select, [10:8] as source-B select, [7:5] as destination select and [4:0] as operation code.
- R2: A source select of 1 to 7 puts register R1 to R7 on its bus. A source select of 0 puts `data_in` on that bus, and both buses may take `data_in` in the same cycle.
- R3: A destination select of 1 to 7 loads the ALU result into R1 to R7 at the rising clock edge. No other register changes.
- R4: A destination select of 0 loads no register.
- R5: `data_out` shows the ALU result of the current control word in the same cycle, including when the destination select is 0.
- R6: The operation codes are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A-B, 00110 A-1, 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A. 10000 is a logical shift right of A and 11000 is a logical shift left of A. Every other code gives zero.
- R7: When one register is both a source and the destination, the source reads the value held before the edge.
- R8: While `rst` is high at a rising edge, every register clears to zero.
- R9: `flags` is {C,S,Z,V}, bits 3 down to 0. S is the result MSB and Z is 1 when the result is zero. For add, subtract, increment and decrement, C is the carry out of A + operand + carry-in (subtract adds NOT B with carry-in 1, increment adds 0 with carry-in 1, decrement adds all ones), and V is set when A and that operand have equal sign bits and the result's sign differs. For shifts, C is the bit shifted out. In every other case C and V are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl | input | 14 | Control word: source A, source B, destination, operation |
| data_in | input | W (8) | External operand, used when a source select is 0 |
| data_out | output | W (8) | ALU result of the current cycle |
| flags | output | 4 | Status {carry, sign, zero, overflow} |

## Verification
The hardest behaviour to reach from the ports is a register that is both read and written in one cycle. The bench drives increment, decrement, add and subtract words with the same register on a source field and on the destination field. It checks the same-cycle result, then reads the register back with a pass-A word to show that the old value fed the ALU. The register contents can only be seen through the ALU, so every write and every suppressed write is confirmed later by reading that register back. Signed overflow and the carry out of a wrap to zero use the external input as an operand, which puts those cases in reach without loading registers first.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
    localparam int SEL_W = 3;
    localparam int OP_W  = 5;
    localparam int CW_W  = 3 * SEL_W + OP_W;
    localparam int FLAG_W = 4;

    localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
    localparam logic [OP_W-1:0] OP_INC  = 5'b00001;
    localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
    localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
    localparam logic [OP_W-1:0] OP_DEC  = 5'b00110;
    localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
    localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
    localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
    localparam logic [OP_W-1:0] OP_NOT  = 5'b01110;
    localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
    localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OP_W-1:0]  op;
    } cword_t;
endpackage

// File: rtl/cwdp_regbank.sv
module cwdp_regbank #(
    parameter int W     = 8,
    parameter int NREG  = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] src_a,
    input  logic [SEL_W-1:0] src_b,
    input  logic [SEL_W-1:0] dst,
    input  logic [W-1:0]     ext_in,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     bus_a,
    output logic [W-1:0]     bus_b
);
    localparam int NDEC = 1 << SEL_W;

    typedef logic [NREG-1:0][W-1:0] bank_t;

    bank_t           regs_d;
    bank_t           regs_q;
    logic [NDEC-1:0] dec_oh;

    // destination decoder; output 0 means "no register"
    always_comb begin
        dec_oh = '0;
        dec_oh[dst] = 1'b1;
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NREG; i++) begin
            if (dec_oh[i+1]) regs_d[i] = wr_data;
        end
        if (rst) regs_d = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // source multiplexers: code 0 takes the external input
    always_comb begin
        bus_a = ext_in;
        bus_b = ext_in;
        for (int i = 0; i < NREG; i++) begin
            if (src_a == SEL_W'(i + 1)) bus_a = regs_q[i];
            if (src_b == SEL_W'(i + 1)) bus_b = regs_q[i];
        end
    end

    // R8: reset clears the whole bank
    a_r8_reset_clear: assert property (@(posedge clk) rst |=> (regs_q == '0));

    // R4: destination 0 leaves the bank untouched
    a_r4_no_write: assert property (@(posedge clk) disable iff (rst)
        (dst == '0) |=> $stable(regs_q));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R3: selected register captures the result
        a_r3_write_sel: assert property (@(posedge clk) disable iff (rst)
            (dst == SEL_W'(g + 1)) |=> (regs_q[g] == $past(wr_data)));
        // R3: unselected registers hold
        a_r3_others_hold: assert property (@(posedge clk) disable iff (rst)
            (dst != SEL_W'(g + 1)) |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/cwdp_alu.sv
module cwdp_alu
    import cwdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [OP_W-1:0]   op,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags
);
    logic [W-1:0] addend;
    logic         cin;
    logic         use_adder;
    logic [W:0]   sum;
    logic         carry;
    logic         ovf;

    always_comb begin
        addend    = '0;
        cin       = 1'b0;
        use_adder = 1'b0;
        unique case (op)
            OP_INC: begin use_adder = 1'b1; cin = 1'b1; end
            OP_ADD: begin use_adder = 1'b1; addend = opb; end
            OP_SUB: begin use_adder = 1'b1; addend = ~opb; cin = 1'b1; end
            OP_DEC: begin use_adder = 1'b1; addend = '1; end
            default: ;
        endcase
    end

    assign sum = {1'b0, opa} + {1'b0, addend} + {{W{1'b0}}, cin};

    always_comb begin
        result = '0;
        carry  = 1'b0;
        ovf    = 1'b0;
        if (use_adder) begin
            result = sum[W-1:0];
            carry  = sum[W];
            ovf    = (opa[W-1] == addend[W-1]) && (sum[W-1] != opa[W-1]);
        end else begin
            case (op)
                OP_PASS: result = opa;
                OP_AND:  result = opa & opb;
                OP_OR:   result = opa | opb;
                OP_XOR:  result = opa ^ opb;
                OP_NOT:  result = ~opa;
                OP_SHR:  begin result = {1'b0, opa[W-1:1]}; carry = opa[0]; end
                OP_SHL:  begin result = {opa[W-2:0], 1'b0}; carry = opa[W-1]; end
                default: result = '0;
            endcase
        end
    end

    assign flags = {carry, result[W-1], (result == '0), ovf};

    // R9: overflow only arises from the adder path
    a_r9_ovf_adder: assert final (!ovf || use_adder);
endmodule

// File: rtl/cwdp_top.sv
module cwdp_top
    import cwdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW_W-1:0]   ctrl,
    input  logic [W-1:0]      data_in,
    output logic [W-1:0]      data_out,
    output logic [FLAG_W-1:0] flags
);
    localparam int NREG = (1 << SEL_W) - 1;

    cword_t       cw;
    logic [W-1:0] bus_a;
    logic [W-1:0] bus_b;
    logic [W-1:0] alu_res;

    assign cw = cword_t'(ctrl);

    cwdp_regbank #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .src_a   (cw.src_a),
        .src_b   (cw.src_b),
        .dst     (cw.dst),
        .ext_in  (data_in),
        .wr_data (alu_res),
        .bus_a   (bus_a),
        .bus_b   (bus_b)
    );

    cwdp_alu #(.W(W)) u_alu (
        .opa    (bus_a),
        .opb    (bus_b),
        .op     (cw.op),
        .result (alu_res),
        .flags  (flags)
    );

    assign data_out = alu_res;

    // R2: external input passes straight through on source A
    a_r2_ext_pass: assert property (@(posedge clk) disable iff (rst)
        (ctrl[13:11] == 3'd0 && ctrl[4:0] == OP_PASS) |-> (data_out == data_in));

    // R6: unassigned operation codes give zero with Z set
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl[4:0] == 5'b11111) |-> (data_out == '0 && flags[1]));
endmodule

// File: tb/tb_cwdp_top.sv
`timescale 1ns/1ps
module tb_cwdp_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ctrl = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cwdp_top dut (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .data_in(data_in), .data_out(data_out), .flags(flags)
    );

    // vector: {src_a, src_b, dst, op, data_in, expected out, expected {C,S,Z,V}}
    localparam int NV = 22;
    localparam logic [33:0] VEC [NV] = '{
        {3'd0,3'd0,3'd1,5'b00000, 8'h12, 8'h12, 4'b0000},  // ext -> R1
        {3'd0,3'd0,3'd2,5'b00000, 8'h34, 8'h34, 4'b0000},  // ext -> R2
        {3'd0,3'd0,3'd3,5'b00000, 8'hF0, 8'hF0, 4'b0100},  // ext -> R3
        {3'd0,3'd0,3'd4,5'b00000, 8'h14, 8'h14, 4'b0000},  // ext -> R4
        {3'd3,3'd4,3'd5,5'b00101, 8'h00, 8'hDC, 4'b1100},  // R3-R4 -> R5
        {3'd1,3'd2,3'd6,5'b00010, 8'h00, 8'h46, 4'b0000},  // R1+R2 -> R6
        {3'd1,3'd2,3'd7,5'b01100, 8'h00, 8'h26, 4'b0000},  // R1^R2 -> R7
        {3'd1,3'd2,3'd0,5'b01000, 8'h00, 8'h10, 4'b0000},  // AND, no write
        {3'd1,3'd2,3'd0,5'b01010, 8'h00, 8'h36, 4'b0000},  // OR, no write
        {3'd5,3'd0,3'd5,5'b00001, 8'h00, 8'hDD, 4'b0100},  // inc R5 in place
        {3'd1,3'd0,3'd1,5'b00110, 8'h00, 8'h11, 4'b1000},  // dec R1 in place
        {3'd3,3'd0,3'd3,5'b01110, 8'h00, 8'h0F, 4'b0000},  // not R3 in place
        {3'd2,3'd0,3'd2,5'b10000, 8'h00, 8'h1A, 4'b0000},  // shr R2 in place
        {3'd3,3'd0,3'd3,5'b11000, 8'h00, 8'h1E, 4'b0000},  // shl R3 in place
        {3'd5,3'd0,3'd0,5'b00000, 8'h00, 8'hDD, 4'b0100},  // read R5
        {3'd5,3'd0,3'd0,5'b10000, 8'h00, 8'h6E, 4'b1000},  // shr out bit 1
        {3'd5,3'd0,3'd0,5'b11000, 8'h00, 8'hBA, 4'b1100},  // shl out bit 1
        {3'd6,3'd6,3'd0,5'b11111, 8'h00, 8'h00, 4'b0010},  // unused code
        {3'd0,3'd6,3'd0,5'b00010, 8'hBA, 8'h00, 4'b1010},  // carry wrap to zero
        {3'd7,3'd0,3'd0,5'b00010, 8'h70, 8'h96, 4'b0101},  // signed overflow
        {3'd1,3'd0,3'd0,5'b00010, 8'h05, 8'h16, 4'b0000},  // B from ext
        {3'd0,3'd0,3'd0,5'b00010, 8'h21, 8'h42, 4'b0000}   // both ext
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] a, input logic [2:0] b,
                         input logic [2:0] d, input logic [4:0] op, input logic [7:0] din);
        @(negedge clk);
        ctrl = {a, b, d, op};
        data_in = din;
        #2;
    endtask

    task automatic readreg(input string tag, input logic [2:0] r, input logic [7:0] exp);
        drive(r, 3'd0, 3'd0, 5'b00000, 8'hA5);
        chk(tag, data_out, exp);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state of the bank
        readreg("R8 reset R1", 3'd1, 8'h00);
        readreg("R8 reset R7", 3'd7, 8'h00);
        chk("R8 reset flags", {4'h0, flags}, 8'h02);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][33:31], VEC[i][30:28], VEC[i][27:25], VEC[i][24:20], VEC[i][19:12]);
            chk($sformatf("R5 R6 vec %0d out", i), data_out, VEC[i][11:4]);
            chk($sformatf("R9 vec %0d flags", i), {4'h0, flags}, {4'h0, VEC[i][3:0]});
        end

        // R3 R4 readback: written registers hold results, AND/OR/test ops wrote nothing
        readreg("R3 R1", 3'd1, 8'h11);
        readreg("R3 R2", 3'd2, 8'h1A);
        readreg("R3 R3", 3'd3, 8'h1E);
        readreg("R4 R4 unchanged", 3'd4, 8'h14);
        readreg("R3 R5", 3'd5, 8'hDD);
        readreg("R4 R6 unchanged", 3'd6, 8'h46);
        readreg("R4 R7 unchanged", 3'd7, 8'h26);

        // R7 same register as both sources and destination
        drive(3'd1, 3'd1, 3'd1, 5'b00010, 8'h00);
        chk("R7 R1+R1 out", data_out, 8'h22);
        readreg("R7 R1 after", 3'd1, 8'h22);
        drive(3'd4, 3'd4, 3'd4, 5'b00101, 8'h00);
        chk("R7 R4-R4 out", data_out, 8'h00);
        chk("R9 R4-R4 flags", {4'h0, flags}, 8'h0A);
        readreg("R7 R4 after", 3'd4, 8'h00);

        // R1 field placement: distinct values in every field
        drive(3'd2, 3'd7, 3'd6, 5'b01100, 8'h00);
        chk("R1 fields out", data_out, 8'h3C);
        readreg("R1 dest field", 3'd6, 8'h3C);

        // R8 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        readreg("R8 R6 after reset", 3'd6, 8'h00);
        readreg("R8 R5 after reset", 3'd5, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule